// File: doc/BRIEF.md
# Multi-Bank Column Window Selector

This block drives the column-enable lines of a scanned single-photon pixel array. It holds four programmable banks. Each bank is a double-buffered register chain: a serial shadow chain that software or a sequencer loads bit by bit, and an active register that drives the columns. Each chain carries a 256-bit column pattern and an 8-bit code stamp. All four shadow chains shift in parallel, one serial data input per bank, under a single shared shift enable. While they shift, the active registers and the enabled columns stay exactly as they were.

A single transfer strobe copies every shadow chain into its active register in one clock. A 2-bit bank select then picks which active bank drives the column lines and the stamp output. The select is meant to switch in step with several lasers that fire in turn, with one bank per laser. A spare bank is usually left all-zero, so that selecting it turns every column off.

A legal window enables at most eight adjacent columns. At each transfer the block records, per bank, whether the incoming pattern breaks this rule.

Top module: `colwin_sel`

## Requirements
- R1: While reset is low, and right after it is released, every column enable, the stamp output and every error flag read zero.
- R2: On each clock with `shift_en` high, every bank's shadow chain shifts by one place and takes its own `ser_in` bit. A full load is 264 shifts. The first 256 bits are columns, sent from column 255 down to column 0. The last 8 bits are the stamp, sent from stamp bit 7 down to stamp bit 0.
- R3: Shifting without a transfer leaves `col_en` and `stamp_out` unchanged.
- R4: A clock with `xfer` high copies all four shadow chains into the active registers. The new columns appear on `col_en` right after that edge.
- R5: `col_en` always shows the column pattern of the active bank chosen by `bank_sel`. It follows a change of `bank_sel` with no clock delay.
- R6: `stamp_out` always shows the stamp of the active bank chosen by `bank_sel`.
- R7: If `xfer` and `shift_en` are high in the same clock, the active registers take the shadow content from before that clock's shift.
- R8: At each transfer, `cfg_err[b]` is set if the pattern loaded into bank b enables more than eight columns, or enables columns that are not all adjacent. It is cleared if the pattern is empty or is one run of 1 to 8 adjacent columns. Columns 255 and 0 are not adjacent. The flag changes only on a transfer.
- R9: Selecting a bank loaded with an all-zero pattern disables every column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_en | input | 1 | Shift all shadow chains by one place |
| ser_in | input | 4 | Serial data, one bit per bank |
| xfer | input | 1 | Copy all shadow chains into the active registers |
| bank_sel | input | 2 | Active bank that drives the outputs |
| col_en | output | 256 | Column enable lines |
| stamp_out | output | 8 | Code stamp of the selected bank |
| cfg_err | output | 4 | Per-bank window rule violation, updated on transfer |

## Verification
The bench loads windows that sit at both edges of the array and in the middle, and it checks every bank select. A reversed bit order would show up at once as windows and stamps appearing mirrored. It reloads the banks while the outputs are live, so a design that leaked shadow bits into the columns during shifting would be caught. It also raises the transfer in the same clock as a final shift, so a design that copied the post-shift content would show a window moved by one column. The error cases cover a nine-column run, two separated columns, and a pair split across column 255 and column 0. These catch a check that only counts bits, or one that treats the array as circular.

// File: rtl/colwin_sel.sv
module colwin_sel #(
  parameter int NCOL   = 256,
  parameter int STW    = 8,
  parameter int NBANK  = 4,
  parameter int MAXWIN = 8,
  localparam int CHW   = NCOL + STW,
  localparam int SELW  = $clog2(NBANK),
  localparam int CNTW  = $clog2(NCOL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [NBANK-1:0] ser_in,
  input  logic             xfer,
  input  logic [SELW-1:0]  bank_sel,
  output logic [NCOL-1:0]  col_en,
  output logic [STW-1:0]   stamp_out,
  output logic [NBANK-1:0] cfg_err
);

  logic [CHW-1:0]   shadow [NBANK];
  logic [CHW-1:0]   active [NBANK];
  logic [NBANK-1:0] bad;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CNTW-1:0] ones, lo, hi;
    logic            seen;

    always_ff @(posedge clk) begin
      if (!rst_n) shadow[b] <= '0;
      else if (shift_en) shadow[b] <= {shadow[b][CHW-2:0], ser_in[b]};
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        active[b]  <= '0;
        cfg_err[b] <= 1'b0;
      end else if (xfer) begin
        active[b]  <= shadow[b];
        cfg_err[b] <= bad[b];
      end
    end

    always_comb begin
      ones = '0;
      lo   = '0;
      hi   = '0;
      seen = 1'b0;
      for (int c = 0; c < NCOL; c++) begin
        if (shadow[b][STW + c]) begin
          ones = ones + 1'b1;
          hi   = CNTW'(c);
          if (!seen) lo = CNTW'(c);
          seen = 1'b1;
        end
      end
      bad[b] = (ones > CNTW'(MAXWIN)) || (seen && ((hi - lo + 1'b1) != ones));
    end

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> shadow[b][0] == $past(ser_in[b]));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(xfer) |-> $stable(cfg_err[b]));
  end

  assign col_en    = active[bank_sel][CHW-1:STW];
  assign stamp_out = active[bank_sel][STW-1:0];

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (col_en == '0 && stamp_out == '0 && cfg_err == '0));

  // R3
  cols_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(xfer) && $stable(bank_sel)) |-> ($stable(col_en) && $stable(stamp_out)));

  // R4
  xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer) && $stable(bank_sel)) |->
      (col_en == $past(shadow[bank_sel][CHW-1:STW]) && stamp_out == $past(shadow[bank_sel][STW-1:0])));

endmodule

// File: tb/sim_colwin_sel.sv
module sim_colwin_sel;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         shift_en = 1'b0;
  logic [3:0]   ser_in = '0;
  logic         xfer = 1'b0;
  logic [1:0]   bank_sel = '0;
  logic [255:0] col_en;
  logic [7:0]   stamp_out;
  logic [3:0]   cfg_err;

  int total = 0;
  int fails = 0;
  string phase = "R1";

  bit [263:0] m_sh [4];
  bit [263:0] m_ac [4];
  bit         m_er [4];
  bit [255:0] pat [4];
  bit [7:0]   stp [4];

  colwin_sel u0 (.clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in),
                 .xfer(xfer), .bank_sel(bank_sel), .col_en(col_en),
                 .stamp_out(stamp_out), .cfg_err(cfg_err));

  always #2 clk = ~clk;

  function automatic bit rule_broken(bit [255:0] p);
    int n = 0;
    int runs = 0;
    for (int c = 0; c < 256; c++) begin
      if (p[c]) begin
        n++;
        if (c == 0 || !p[c-1]) runs++;
      end
    end
    return (n > 8) || (runs > 1);
  endfunction

  always @(posedge clk) begin
    for (int b = 0; b < 4; b++) begin
      if (!rst_n) begin
        m_sh[b] = '0; m_ac[b] = '0; m_er[b] = 1'b0;
      end else begin
        if (xfer) begin
          m_ac[b] = m_sh[b];
          m_er[b] = rule_broken(m_sh[b][263:8]);
        end
        if (shift_en) m_sh[b] = {m_sh[b][262:0], ser_in[b]};
      end
    end
  end

  task automatic chk(string r, bit ok, logic [255:0] act, logic [255:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk({phase, " col_en"}, col_en == m_ac[bank_sel][263:8], col_en, m_ac[bank_sel][263:8]);
    chk("R6 stamp_out", stamp_out == m_ac[bank_sel][7:0], 256'(stamp_out), 256'(m_ac[bank_sel][7:0]));
    chk("R8 cfg_err", cfg_err == {m_er[3], m_er[2], m_er[1], m_er[0]}, 256'(cfg_err),
        256'({m_er[3], m_er[2], m_er[1], m_er[0]}));
  endtask

  task automatic load_all();
    for (int i = 0; i < 264; i++) begin
      tick();
      shift_en = 1'b1;
      for (int b = 0; b < 4; b++)
        ser_in[b] = (i < 256) ? pat[b][255 - i] : stp[b][7 - (i - 256)];
    end
    tick();
    shift_en = 1'b0;
    ser_in = '0;
  endtask

  task automatic do_xfer();
    tick();
    xfer = 1'b1;
    tick();
    xfer = 1'b0;
  endtask

  task automatic sweep_sel(string r);
    for (int s = 0; s < 4; s++) begin
      bank_sel = 2'(s);
      #1;
      chk(r, col_en == pat[s], col_en, pat[s]);
      chk("R6 stamp", stamp_out == stp[s], 256'(stamp_out), 256'(stp[s]));
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 reset cols", col_en == '0, col_en, '0);
    chk("R1 reset err", cfg_err == '0, 256'(cfg_err), '0);
    rst_n = 1'b1;
    tick();
    chk("R1 after release", col_en == '0 && stamp_out == '0, col_en, '0);

    phase = "R2";
    pat[0] = 256'hFF;            stp[0] = 8'hA5;
    pat[1] = 256'hFF << 248;     stp[1] = 8'h3C;
    pat[2] = 256'hF << 100;      stp[2] = 8'h81;
    pat[3] = '0;                 stp[3] = 8'h0F;
    load_all();
    phase = "R3";
    chk("R3 shadow not live", col_en == '0, col_en, '0);
    do_xfer();
    phase = "R4";
    sweep_sel("R4 R5 first load");
    bank_sel = 2'd3;
    #1;
    chk("R9 all-off bank", col_en == '0, col_en, '0);
    chk("R8 legal windows", cfg_err == 4'b0000, 256'(cfg_err), '0);

    phase = "R3";
    bank_sel = 2'd2;
    pat[0] = 256'h1FF << 40;     stp[0] = 8'h11;
    pat[1] = (256'h1 << 10) | (256'h1 << 12); stp[1] = 8'h22;
    pat[2] = (256'h1 << 255) | 256'h1;       stp[2] = 8'h33;
    pat[3] = 256'hFF << 120;     stp[3] = 8'h44;
    load_all();
    chk("R3 live cols kept", col_en == (256'hF << 100), col_en, 256'hF << 100);
    phase = "R7";
    tick();
    xfer = 1'b1;
    shift_en = 1'b1;
    ser_in = 4'b1010;
    tick();
    xfer = 1'b0;
    shift_en = 1'b0;
    ser_in = '0;
    phase = "R8";
    sweep_sel("R7 pre-shift copy");
    chk("R8 error flags", cfg_err == 4'b0111, 256'(cfg_err), 256'(4'b0111));

    for (int b = 0; b < 4; b++) begin
      pat[b] = '0;
      stp[b] = 8'(b + 1);
    end
    pat[1] = 256'h1 << 7;
    load_all();
    chk("R8 flag held until xfer", cfg_err == 4'b0111, 256'(cfg_err), 256'(4'b0111));
    do_xfer();
    sweep_sel("R9 R4 reload");
    chk("R8 flags cleared", cfg_err == 4'b0000, 256'(cfg_err), '0);

    repeat (4) tick();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule